// File: doc/BRIEF.md
# NAND Page Operation Sequencer

This block turns one high-level request into the complete byte-level sequence a raw NAND flash device expects. A request carries an operation (page read, page program or block erase), a page number, an OOB-only flag and the device geometry: whether the part has small or large pages, and how many address cycles it takes. The sequencer then issues command bytes and address bytes on a strobed byte bus and moves page data through ready/valid ports. It waits for the device to finish, either by watching the ready/busy pin or by polling the status byte, and it checks the final status.

Small-page and large-page parts differ in three ways. Their column bytes are laid out differently. They redirect OOB-only reads differently: on a small-page part the command changes, and on a large-page part the column changes. Only a large-page read needs a separate start command after its address. The wait for the device is bounded by a timeout that counts in ticks of `TICK_DIV` clock cycles, with a longer limit for erase than for page operations. Each accepted request ends with exactly one result pulse: done, fail or timeout.

Top module: `nand_seq`

## Requirements
- R1: A request on `req_valid_i` is accepted only while `busy_o` is low. `busy_o` goes high in the cycle after acceptance. A request raised while busy has no effect on the byte sequence being issued.
- R2: Small-page addressing (`large_page_i`=0) sends one column byte 0x00, then the row bytes of `req_page_i` least significant first. There are two row bytes, three when `addr_cycles_i`>=4 and four when `addr_cycles_i`>=5.
- R3: Large-page addressing sends two column bytes, 0x00 then 0x00, or 0x00 then 0x08 for a read with `req_oob_i`=1. The row bytes follow, least significant first: two, or three when `addr_cycles_i`>=5.
- R4: A read (`req_op_i`=0) issues command 0x00, or 0x50 on a small-page part with `req_oob_i`=1, then the address. A large-page read then issues command 0x30. The read waits on the ready pin and then streams 512 (small) or 2048 (large) bytes, or 16 or 64 bytes when OOB-only, out of `rd_data_o`. No data is read while the device is busy.
- R5: A program (`req_op_i`=1) issues 0x80 and then the full address, using column 0 whatever `req_oob_i` says. It then forwards 512 or 2048 bytes taken from the write port and issues 0x10. After that it waits and reads status: command 0x70 followed by one data read.
- R6: An erase (`req_op_i`=2) issues 0x60, the row bytes only with no column byte, and then 0xD0. It then waits and reads status the same way as a program.
- R7: If status bit 0 is set when a program or erase reads status, the request ends with `fail_o` instead of `done_o`.
- R8: Suppose the ready condition is not seen within PAGE_UNITS*TICK_DIV cycles (read and program) or ERASE_UNITS*TICK_DIV cycles (erase) after the last command. Then the request ends with `timeout_o` and issues no status read. In pin mode, `timeout_o` rises exactly limit+1 cycles after the cycle that carries the confirm command.
- R9: With `poll_status_i`=1, a program or erase ignores the ready pin. It issues 0x70 and reads status bytes until bit 6 is set, then issues a fresh 0x70 and reads the final status. A read always waits on the pin.
- R10: Each accepted request produces exactly one one-cycle pulse on `done_o`, `fail_o` or `timeout_o`, and `busy_o` is low in that cycle.
- R11: During and after reset, with no request made, `busy_o` is low and no strobe or result pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 2 | 0 read, 1 program, 2 erase |
| req_page_i | input | ROW_W | Page (row) number |
| req_oob_i | input | 1 | Read the spare area only |
| large_page_i | input | 1 | Part has 2048-byte pages |
| addr_cycles_i | input | 3 | Address cycles of the part (3 to 5) |
| poll_status_i | input | 1 | Wait by status polling instead of the pin |
| busy_o | output | 1 | A request is in progress |
| cmd_we_o | output | 1 | `bus_byte_o` carries a command byte |
| addr_we_o | output | 1 | `bus_byte_o` carries an address byte |
| data_we_o | output | 1 | `bus_byte_o` carries a data byte for the device |
| data_re_o | output | 1 | Device data byte consumed this cycle |
| bus_byte_o | output | 8 | Byte driven to the device |
| dev_data_i | input | 8 | Byte returned by the device |
| dev_ready_i | input | 1 | Device ready/busy pin, high when ready |
| wr_data_i | input | 8 | Program data from the host |
| wr_valid_i | input | 1 | Program data valid |
| wr_ready_o | output | 1 | Sequencer takes program data |
| rd_data_o | output | 8 | Read data to the host |
| rd_valid_o | output | 1 | Read data valid |
| rd_ready_i | input | 1 | Host takes read data |
| done_o | output | 1 | Request completed |
| fail_o | output | 1 | Status reported failure |
| timeout_o | output | 1 | Ready wait expired |

## Verification
The assertions assume that the device model drives the ready pin low in the cycle after a command that starts internal work, so that the sequencer never sees a stale ready. They also assume that a request's operation code is 0, 1 or 2 and that the limit is at least two ticks long. The bench keeps within these assumptions. It models the device as dropping ready at the negative edge of the cycle that carries a busy-starting command, and it holds each busy period longer than the remaining address bytes. Host handshakes stall on fixed cycle patterns, and the bench issues only the three defined operations, each with geometries of 3 to 5 cycles.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } nand_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CMD1,
    S_ADDR,
    S_DWR,
    S_CMD2,
    S_WAIT,
    S_PCMD,
    S_POLL,
    S_SCMD,
    S_SRD,
    S_DRD
  } seq_state_e;

  localparam logic [7:0] CMD_RD       = 8'h00;
  localparam logic [7:0] CMD_RD_SPARE = 8'h50;
  localparam logic [7:0] CMD_RD_GO    = 8'h30;
  localparam logic [7:0] CMD_LOAD     = 8'h80;
  localparam logic [7:0] CMD_PROG     = 8'h10;
  localparam logic [7:0] CMD_ERS_SET  = 8'h60;
  localparam logic [7:0] CMD_ERS_GO   = 8'hD0;
  localparam logic [7:0] CMD_STAT     = 8'h70;

  localparam int STAT_FAIL_BIT = 0;
  localparam int STAT_RDY_BIT  = 6;

endpackage

// File: rtl/nand_addr_gen.sv
module nand_addr_gen #(
  parameter int ROW_W = 32
) (
  input  logic [ROW_W-1:0] page_i,
  input  logic             large_i,
  input  logic [2:0]       cycles_i,
  input  logic             spare_col_i,
  input  logic             row_only_i,
  input  logic [2:0]       idx_i,
  output logic [7:0]       byte_o,
  output logic             last_o
);

  logic [2:0] n_col, n_row, n_tot, row_k;
  logic [ROW_W-1:0] shifted;

  always_comb begin
    n_col = row_only_i ? 3'd0 : (large_i ? 3'd2 : 3'd1);
    if (large_i)
      n_row = 3'd2 + {2'b0, cycles_i >= 3'd5};
    else
      n_row = 3'd2 + {2'b0, cycles_i >= 3'd4} + {2'b0, cycles_i >= 3'd5};
    n_tot   = n_col + n_row;
    row_k   = idx_i - n_col;
    shifted = page_i >> {row_k, 3'b000};
    if (idx_i < n_col)
      byte_o = (large_i && idx_i == 3'd1 && spare_col_i) ? 8'h08 : 8'h00;
    else
      byte_o = shifted[7:0];
    last_o = (idx_i == n_tot - 3'd1);
  end

endmodule

// File: rtl/nand_wait_timer.sv
module nand_wait_timer #(
  parameter int TICK_DIV    = 50000,
  parameter int PAGE_UNITS  = 100,
  parameter int ERASE_UNITS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic long_i,
  output logic expire_o
);

  localparam int PAGE_LIM  = PAGE_UNITS * TICK_DIV;
  localparam int ERASE_LIM = ERASE_UNITS * TICK_DIV;
  localparam int MAX_LIM   = (ERASE_LIM > PAGE_LIM) ? ERASE_LIM : PAGE_LIM;
  localparam int CNT_W     = $clog2(MAX_LIM + 1);

  logic [CNT_W-1:0] cnt_q, lim;

  assign lim      = long_i ? CNT_W'(ERASE_LIM) : CNT_W'(PAGE_LIM);
  assign expire_o = run_i && (cnt_q == lim - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else              cnt_q <= cnt_q + CNT_W'(1);
  end

  // R8
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < lim));

endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int ROW_W       = 32,
  parameter int SMALL_PAGE  = 512,
  parameter int LARGE_PAGE  = 2048,
  parameter int SMALL_SPARE = 16,
  parameter int LARGE_SPARE = 64,
  parameter int TICK_DIV    = 50000,
  parameter int PAGE_UNITS  = 100,
  parameter int ERASE_UNITS = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [1:0]       req_op_i,
  input  logic [ROW_W-1:0] req_page_i,
  input  logic             req_oob_i,
  input  logic             large_page_i,
  input  logic [2:0]       addr_cycles_i,
  input  logic             poll_status_i,
  output logic             busy_o,
  output logic             cmd_we_o,
  output logic             addr_we_o,
  output logic             data_we_o,
  output logic             data_re_o,
  output logic [7:0]       bus_byte_o,
  input  logic [7:0]       dev_data_i,
  input  logic             dev_ready_i,
  input  logic [7:0]       wr_data_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  output logic             done_o,
  output logic             fail_o,
  output logic             timeout_o
);

  localparam int LEN_W = $clog2(LARGE_PAGE + 1);

  seq_state_e       st_q, st_d;
  nand_op_e         op_q;
  logic [ROW_W-1:0] page_q;
  logic             oob_q, large_q, poll_q;
  logic [2:0]       cyc_q, idx_q;
  logic [LEN_W-1:0] cnt_q, len;
  logic [7:0]       addr_byte, cmd1, cmd2;
  logic             addr_last, expire, run_wait;
  logic             fin_done, fin_fail, fin_tmo;

  nand_addr_gen #(.ROW_W(ROW_W)) i_addr (
    .page_i      (page_q),
    .large_i     (large_q),
    .cycles_i    (cyc_q),
    .spare_col_i (oob_q && op_q == OP_READ),
    .row_only_i  (op_q == OP_ERASE),
    .idx_i       (idx_q),
    .byte_o      (addr_byte),
    .last_o      (addr_last)
  );

  assign run_wait = (st_q == S_WAIT) || (st_q == S_PCMD) || (st_q == S_POLL);

  nand_wait_timer #(
    .TICK_DIV    (TICK_DIV),
    .PAGE_UNITS  (PAGE_UNITS),
    .ERASE_UNITS (ERASE_UNITS)
  ) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_wait),
    .long_i   (op_q == OP_ERASE),
    .expire_o (expire)
  );

  // transfer length and command bytes for the latched request
  always_comb begin
    if (op_q == OP_READ && oob_q)
      len = large_q ? LEN_W'(LARGE_SPARE) : LEN_W'(SMALL_SPARE);
    else
      len = large_q ? LEN_W'(LARGE_PAGE) : LEN_W'(SMALL_PAGE);
    case (op_q)
      OP_PROG:  begin cmd1 = CMD_LOAD;    cmd2 = CMD_PROG;   end
      OP_ERASE: begin cmd1 = CMD_ERS_SET; cmd2 = CMD_ERS_GO; end
      default:  begin
        cmd1 = (!large_q && oob_q) ? CMD_RD_SPARE : CMD_RD;
        cmd2 = CMD_RD_GO;
      end
    endcase
  end

  // bus outputs
  always_comb begin
    cmd_we_o   = 1'b0;
    addr_we_o  = 1'b0;
    bus_byte_o = 8'h00;
    case (st_q)
      S_CMD1: begin cmd_we_o = 1'b1; bus_byte_o = cmd1; end
      S_ADDR: begin addr_we_o = 1'b1; bus_byte_o = addr_byte; end
      S_DWR:  bus_byte_o = wr_data_i;
      S_CMD2: begin cmd_we_o = 1'b1; bus_byte_o = cmd2; end
      S_PCMD, S_SCMD: begin cmd_we_o = 1'b1; bus_byte_o = CMD_STAT; end
      default: ;
    endcase
  end

  assign busy_o     = (st_q != S_IDLE);
  assign wr_ready_o = (st_q == S_DWR);
  assign data_we_o  = wr_ready_o && wr_valid_i;
  assign rd_valid_o = (st_q == S_DRD);
  assign rd_data_o  = dev_data_i;
  assign data_re_o  = (rd_valid_o && rd_ready_i) || (st_q == S_POLL) || (st_q == S_SRD);

  // next state
  always_comb begin
    st_d     = st_q;
    fin_done = 1'b0;
    fin_fail = 1'b0;
    fin_tmo  = 1'b0;
    case (st_q)
      S_IDLE: if (req_valid_i) st_d = S_CMD1;
      S_CMD1: st_d = S_ADDR;
      S_ADDR: if (addr_last) begin
        case (op_q)
          OP_PROG:  st_d = S_DWR;
          OP_ERASE: st_d = S_CMD2;
          default:  st_d = large_q ? S_CMD2 : S_WAIT;
        endcase
      end
      S_DWR:  if (wr_valid_i && cnt_q == len - LEN_W'(1)) st_d = S_CMD2;
      S_CMD2: st_d = (op_q != OP_READ && poll_q) ? S_PCMD : S_WAIT;
      S_WAIT: begin
        if (dev_ready_i)  st_d = (op_q == OP_READ) ? S_DRD : S_SCMD;
        else if (expire) begin st_d = S_IDLE; fin_tmo = 1'b1; end
      end
      S_PCMD: st_d = S_POLL;
      S_POLL: begin
        if (dev_data_i[STAT_RDY_BIT]) st_d = S_SCMD;
        else if (expire) begin st_d = S_IDLE; fin_tmo = 1'b1; end
      end
      S_SCMD: st_d = S_SRD;
      S_SRD: begin
        st_d     = S_IDLE;
        fin_fail = dev_data_i[STAT_FAIL_BIT];
        fin_done = !dev_data_i[STAT_FAIL_BIT];
      end
      S_DRD: if (rd_ready_i && cnt_q == len - LEN_W'(1)) begin
        st_d     = S_IDLE;
        fin_done = 1'b1;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      op_q      <= OP_READ;
      page_q    <= '0;
      oob_q     <= 1'b0;
      large_q   <= 1'b0;
      poll_q    <= 1'b0;
      cyc_q     <= 3'd3;
      idx_q     <= '0;
      cnt_q     <= '0;
      done_o    <= 1'b0;
      fail_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      st_q      <= st_d;
      done_o    <= fin_done;
      fail_o    <= fin_fail;
      timeout_o <= fin_tmo;
      if (st_q == S_IDLE && req_valid_i) begin
        op_q    <= nand_op_e'(req_op_i);
        page_q  <= req_page_i;
        oob_q   <= req_oob_i;
        large_q <= large_page_i;
        poll_q  <= poll_status_i;
        cyc_q   <= addr_cycles_i;
        idx_q   <= '0;
        cnt_q   <= '0;
      end
      if (st_q == S_ADDR) idx_q <= idx_q + 3'd1;
      if ((st_q == S_DWR && wr_valid_i) || (st_q == S_DRD && rd_ready_i))
        cnt_q <= (st_d != st_q) ? '0 : cnt_q + LEN_W'(1);
    end
  end

  // R10
  outcome_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, fail_o, timeout_o}));

  // R10
  outcome_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fail_o || timeout_o) |-> !busy_o);

  // R1
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_valid_i) |=> ($stable(op_q) && $stable(page_q)));

  // R4
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_we_o, addr_we_o, data_we_o, data_re_o}));

  // R2
  addr_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_we_o && !addr_last) |=> addr_we_o);

endmodule

// File: tb/test_nand_seq.sv
module test_nand_seq;

  localparam int TICK = 2;
  localparam int PLIM = 100 * TICK;
  localparam int ELIM = 1000 * TICK;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_oob_i = 1'b0, large_page_i = 1'b0, poll_status_i = 1'b0;
  logic [1:0] req_op_i = 2'd0;
  logic [31:0] req_page_i = '0;
  logic [2:0] addr_cycles_i = 3'd3;
  logic busy_o, cmd_we_o, addr_we_o, data_we_o, data_re_o, wr_ready_o, rd_valid_o;
  logic done_o, fail_o, timeout_o, dev_ready_i;
  logic [7:0] bus_byte_o, dev_data_i, wr_data_i, rd_data_o;
  logic wr_valid_i = 1'b0, rd_ready_i = 1'b0;

  int cyc = 0, n_tests = 0, n_fail = 0;
  logic [8:0] log_q [0:31];
  logic [8:0] exp_q [0:31];
  int log_n = 0, exp_n = 0;
  int busy_cnt = 0, busy_len = 12, rd_idx = 0;
  bit stat_mode = 0, stat_bad = 0, poll_tb = 0, finished = 0;
  int wr_seen = 0, wr_bad = 0, rd_got = 0, rd_bad = 0, viol = 0;
  int n_done = 0, n_fl = 0, n_to = 0, t_conf = 0, t_to = 0;

  always #10 clk_i = ~clk_i;

  function automatic logic [7:0] rpat(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction
  function automatic logic [7:0] wpat(input int i);
    return 8'(((i * 11 + 5) & 255) ^ ((i >> 8) & 255));
  endfunction

  assign dev_ready_i = (busy_cnt == 0);
  assign dev_data_i  = stat_mode ? {1'b0, busy_cnt == 0, 5'b0, stat_bad} : rpat(rd_idx);
  assign wr_data_i   = wpat(wr_seen);

  nand_seq #(.TICK_DIV(TICK)) i_nand_seq (.*);

  // device and host model: samples mid-cycle
  always @(negedge clk_i) begin
    cyc++;
    if (data_re_o && busy_cnt != 0 && !(stat_mode && poll_tb)) viol++;
    if (rd_valid_o && rd_ready_i) begin
      if (rd_data_o != rpat(rd_got)) rd_bad++;
      rd_got++;
    end
    if (data_re_o && !stat_mode) rd_idx++;
    if (data_we_o) begin
      if (bus_byte_o != wpat(wr_seen)) wr_bad++;
      wr_seen++;
    end
    if (busy_cnt > 0) busy_cnt--;
    if (cmd_we_o || addr_we_o) begin
      if (log_n < 32) log_q[log_n] = {addr_we_o, bus_byte_o};
      log_n++;
    end
    if (cmd_we_o) begin
      case (bus_byte_o)
        8'h00, 8'h50: begin stat_mode = 0; rd_idx = 0; busy_cnt = busy_len; end
        8'h30: busy_cnt = busy_len;
        8'h10, 8'hD0: begin busy_cnt = busy_len; t_conf = cyc; end
        8'h70: stat_mode = 1;
        default: stat_mode = 0;
      endcase
    end
    if (done_o) n_done++;
    if (fail_o) n_fl++;
    if (timeout_o) begin n_to++; t_to = cyc; end
  end

  always begin
    @(posedge clk_i); #2;
    wr_valid_i = (cyc % 5) != 2;
    rd_ready_i = (cyc % 3) != 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic push(input logic [8:0] v);
    exp_q[exp_n] = v;
    exp_n++;
  endtask

  // outcome: 0 done, 1 fail, 2 timeout
  task automatic build_exp(input int op, input logic [31:0] pg, input bit lg,
                           input int cy, input bit oob, input bit poll, input int outc);
    int nrow;
    exp_n = 0;
    if (op == 0)      push({1'b0, (!lg && oob) ? 8'h50 : 8'h00});
    else if (op == 1) push({1'b0, 8'h80});
    else              push({1'b0, 8'h60});
    if (op != 2) begin
      push({1'b1, 8'h00});
      if (lg) push({1'b1, (op == 0 && oob) ? 8'h08 : 8'h00});
    end
    nrow = lg ? 2 + (cy >= 5 ? 1 : 0) : 2 + (cy >= 4 ? 1 : 0) + (cy >= 5 ? 1 : 0);
    for (int k = 0; k < nrow; k++) push({1'b1, pg[8*k +: 8]});
    if (op == 0 && lg) push({1'b0, 8'h30});
    if (op == 1) push({1'b0, 8'h10});
    if (op == 2) push({1'b0, 8'hD0});
    if (op != 0 && poll) push({1'b0, 8'h70});
    if (op != 0 && outc != 2) push({1'b0, 8'h70});
  endtask

  task automatic run_op(input int op, input logic [31:0] pg, input bit lg, input int cy,
                        input bit oob, input bit poll, input int blen, input bit sbad,
                        input int outc, input bit inject);
    string stag;
    bit seq_ok;
    int len;
    @(posedge clk_i); #2;
    log_n = 0; wr_seen = 0; wr_bad = 0; rd_got = 0; rd_bad = 0; viol = 0;
    n_done = 0; n_fl = 0; n_to = 0; busy_cnt = 0; stat_mode = 0;
    busy_len = blen; stat_bad = sbad; poll_tb = poll;
    req_op_i = 2'(op); req_page_i = pg; large_page_i = lg; addr_cycles_i = 3'(cy);
    req_oob_i = oob; poll_status_i = poll; req_valid_i = 1'b1;
    @(posedge clk_i); #2;
    req_valid_i = 1'b0;
    @(negedge clk_i);
    chk(busy_o == 1'b1, "R1 busy after accept", int'(busy_o), 1);
    if (inject) begin
      repeat (3) @(posedge clk_i);
      #2;
      req_op_i = 2'd2; req_page_i = ~pg; req_valid_i = 1'b1;
      @(posedge clk_i); #2;
      req_valid_i = 1'b0;
    end
    while (n_done + n_fl + n_to == 0 && cyc < 195000) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    build_exp(op, pg, lg, cy, oob, poll, outc);
    seq_ok = (log_n == exp_n);
    for (int k = 0; k < exp_n && k < 32; k++)
      if (seq_ok && log_q[k] != exp_q[k]) begin
        seq_ok = 0;
        $display("  entry %0d: got %h want %h", k, log_q[k], exp_q[k]);
      end
    stag = (op == 0) ? (lg ? "R3 read addr seq" : "R2 read addr seq")
         : (op == 1) ? (inject ? "R1 ignored req seq" : "R5 program seq") : "R6 erase seq";
    chk(seq_ok, stag, log_n, exp_n);
    if (outc == 0)
      chk(n_done == 1 && n_fl == 0 && n_to == 0, "R10 single done", n_done + 10 * n_fl + 100 * n_to, 1);
    else if (outc == 1)
      chk(n_fl == 1 && n_done == 0 && n_to == 0, "R7 status fail", n_done + 10 * n_fl + 100 * n_to, 10);
    else
      chk(n_to == 1 && n_done == 0 && n_fl == 0, "R8 timeout", n_done + 10 * n_fl + 100 * n_to, 100);
    if (op == 0 && outc == 0) begin
      len = oob ? (lg ? 64 : 16) : (lg ? 2048 : 512);
      chk(rd_got == len && rd_bad == 0, "R4 read data", rd_got - 10000 * rd_bad, len);
    end
    if (op == 1) begin
      len = lg ? 2048 : 512;
      chk(wr_seen == len && wr_bad == 0, "R5 program data", wr_seen - 10000 * wr_bad, len);
    end
    chk(viol == 0, (op == 0) ? "R4 read before ready" : "R9 status read while busy", viol, 0);
    busy_cnt = 0;
  endtask

  always @(negedge clk_i) begin
    if (cyc > 199000 && !finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 199000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] pg;
    repeat (3) @(negedge clk_i);
    // R11
    chk(!busy_o && !cmd_we_o && !addr_we_o && !data_we_o && !data_re_o, "R11 reset idle",
        int'({busy_o, cmd_we_o, addr_we_o, data_we_o, data_re_o}), 0);
    @(posedge clk_i); #2; rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(!busy_o && !done_o && !fail_o && !timeout_o && !cmd_we_o, "R11 after reset",
        int'({busy_o, done_o, fail_o, timeout_o, cmd_we_o}), 0);

    pg = 32'hA4C3B2D1;
    // reads: every geometry and spare flag
    for (int lg = 0; lg < 2; lg++)
      for (int cy = 3 + lg; cy <= 5; cy++)
        for (int oob = 0; oob < 2; oob++) begin
          run_op(0, pg, lg[0], cy, oob[0], 0, 12, 0, 0, 0);
          pg = pg * 32'd1103515245 + 32'd12345;
        end
    // programs and erases: every geometry, pin and poll mode
    for (int lg = 0; lg < 2; lg++)
      for (int cy = 3 + lg; cy <= 5; cy++)
        for (int poll = 0; poll < 2; poll++) begin
          run_op(1, pg, lg[0], cy, poll[0], poll[0], 15, 0, 0, 0);
          pg = pg * 32'd1103515245 + 32'd12345;
          run_op(2, pg, lg[0], cy, 0, poll[0], 20, 0, 0, 0);
          pg = pg * 32'd1103515245 + 32'd12345;
        end
    // R1: request raised while busy is ignored
    run_op(1, 32'h00C0FFEE, 1, 5, 0, 0, 10, 0, 0, 1);
    // R7: status fail bit on erase and program
    run_op(2, 32'h00012345, 0, 4, 0, 0, 10, 1, 1, 0);
    run_op(1, 32'h00054321, 1, 4, 0, 1, 10, 1, 1, 0);
    // R8: exact timeout distance for page and erase limits
    run_op(1, 32'h00000777, 0, 3, 0, 0, 1000000, 0, 2, 0);
    chk(t_to - t_conf == PLIM + 1, "R8 page timeout distance", t_to - t_conf, PLIM + 1);
    run_op(2, 32'h00000888, 1, 5, 0, 0, 1000000, 0, 2, 0);
    chk(t_to - t_conf == ELIM + 1, "R8 erase timeout distance", t_to - t_conf, ELIM + 1);
    // R9: poll-mode timeout, and read timeout
    run_op(2, 32'h00000999, 0, 5, 0, 1, 1000000, 0, 2, 0);
    run_op(0, 32'h00000AAA, 1, 4, 0, 0, 1000000, 0, 2, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule